// File: doc/BRIEF.md
# USB Control SETUP Receiver

This block handles the SETUP stage of a USB control transfer on the device side. The serial interface engine decodes a SETUP token and pulses `setup_start`. The block then takes the DATA0 payload as a byte stream. Each byte comes with a valid strobe, and the final byte also carries a last strobe. The eight request bytes go into a staging buffer while a CRC16 runs over all ten bytes, which are the eight request bytes and the two CRC bytes.

When the last byte arrives, the block decides the outcome. If the packet is good, it commits the request into five field registers and pulses an ACK request to the transmit side. It sets the status to DATAIN and the data toggle to 1. It also reports whether the request is one the hardware services itself. If firmware must service it, the block raises a setup interrupt. Finally it classifies the transfer as control read, control write, or control write with no data stage. If the packet is bad, the status becomes RX_ERR and no ACK is requested, so the host retries.

Top module: `usb_setup_rx`

## Requirements
- R1: After reset, `status` is 0 (idle). `data_toggle`, `ack_req`, `setup_irq`, `hw_req` and `xfer_type` are 0, and all request field registers are 0.
- R2: On success, the payload bytes map to the fields as follows, with 16-bit fields taken low byte first:
  - byte 0 goes to `req_type`;
  - byte 1 goes to `req_code`;
  - bytes 2–3 go to `req_value`;
  - bytes 4–5 go to `req_index`;
  - bytes 6–7 go to `req_length`.
- R3: A packet is good when all of the following hold:
  - it has exactly 10 bytes, ending with the byte that carries `rx_last`;
  - `rx_data0` is 1 on the last byte;
  - bytes 8–9 hold the ones-complement of the CRC16 of bytes 0–7, low byte first (reflected polynomial 0xA001, preset 0xFFFF; equivalently, x^16+x^15+x^2+1 leaves residual 0x800D).
  A good packet raises `ack_req` for exactly the one cycle after the clock edge that takes the last byte.
- R4: On a CRC mismatch, `status` becomes 2 (RX_ERR) and neither `ack_req` nor `setup_irq` pulses. The request registers keep their previous values.
- R5: A packet whose last strobe comes with fewer than 10 bytes or more than 10 bytes is an RX_ERR (status 2) and gets no ACK.
- R6: A packet whose `rx_data0` is 0 on its last byte is an RX_ERR (status 2) and gets no ACK.
- R7: After a good packet, `status` is 1 (DATAIN) and `data_toggle` is 1.
- R8: A request is hardware-handled when `req_type[6:5]` is 00 (standard) and the code is one of 5, 8, 9, 10 or 11. For such a request, `hw_req` is 1 and `setup_irq` does not pulse.
- R9: Any other good request, including class or vendor requests that use those same codes, gives `hw_req` = 0 and a one-cycle `setup_irq` pulse in the same cycle as `ack_req`.
- R10: `xfer_type` is set as follows:
  - 1 (control read) when the length is nonzero and `req_type[7]` is 1;
  - 2 (control write) when the length is nonzero and `req_type[7]` is 0;
  - 3 (write, no data stage) when the length is 0.
- R11: Bytes presented while no packet is open, meaning no `setup_start` since the last packet ended, are ignored. No ACK is requested and `status` and the field registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_start | input | 1 | SETUP token decoded; opens a new payload |
| rx_valid | input | 1 | `rx_byte` holds a payload byte this cycle |
| rx_byte | input | 8 | Payload byte |
| rx_last | input | 1 | Current byte is the last of the packet |
| rx_data0 | input | 1 | Packet PID was DATA0 (sampled with last byte) |
| ack_req | output | 1 | One-cycle request to send an ACK handshake |
| setup_irq | output | 1 | One-cycle interrupt for firmware-serviced requests |
| hw_req | output | 1 | Last committed request is hardware-serviced |
| status | output | 2 | 0 idle, 1 DATAIN, 2 RX_ERR |
| data_toggle | output | 1 | Data toggle for the next stage |
| xfer_type | output | 2 | 1 read, 2 write, 3 write without data stage |
| req_type | output | 8 | Request type byte |
| req_code | output | 8 | Request code byte |
| req_value | output | 16 | Value field |
| req_index | output | 16 | Index field |
| req_length | output | 16 | Length field |

## Verification
Every result is registered at the clock edge that samples the byte carrying `rx_last`. This applies to the ACK and interrupt pulses, the status, the toggle, the field registers, the hardware flag and the transfer type. All of them are therefore due one edge after that byte, and the pulses drop again one edge later. The bench drives each byte on a falling edge and samples all results at the next falling edge after the last byte. It then samples one cycle further to confirm the pulses lasted only a single cycle. Error and ignored-input cases are sampled in the same slot, so a missing ACK and unchanged fields are seen exactly where a success would have shown.

// File: rtl/usb_setup_rx.sv
module usb_setup_rx #(
  parameter int REQ_BYTES = 8,
  parameter int CRC_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        setup_start,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_last,
  input  logic        rx_data0,
  output logic        ack_req,
  output logic        setup_irq,
  output logic        hw_req,
  output logic [1:0]  status,
  output logic        data_toggle,
  output logic [1:0]  xfer_type,
  output logic [7:0]  req_type,
  output logic [7:0]  req_code,
  output logic [15:0] req_value,
  output logic [15:0] req_index,
  output logic [15:0] req_length
);
  localparam int PKT_BYTES = REQ_BYTES + CRC_BYTES;
  localparam int CW        = $clog2(PKT_BYTES + 2);
  localparam logic [CW-1:0] CNT_SAT  = CW'(PKT_BYTES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PKT_BYTES - 1);
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_RESID  = 16'hB001;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_DATAIN = 2'd1, ST_RXERR = 2'd2;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [15:0]   crc;
  logic [7:0]    sh [REQ_BYTES];

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = ((r[0] ^ d[i]) != 1'b0) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  wire        take   = busy & rx_valid;
  wire [15:0] crc_nx = crc_step(crc, rx_byte);
  wire        done   = take & rx_last;
  wire        good   = done && (cnt == CNT_LAST) && (crc_nx == CRC_RESID) && rx_data0;

  wire [15:0] len_in = {sh[7], sh[6]};
  wire        std_in = (sh[0][6:5] == 2'b00);
  wire        hw_code = (sh[1] == 8'd5) || (sh[1] == 8'd8) || (sh[1] == 8'd9) ||
                        (sh[1] == 8'd10) || (sh[1] == 8'd11);
  wire        hw_in  = std_in && hw_code;
  wire [1:0]  xt_in  = (len_in == 16'd0) ? 2'd3 : (sh[0][7] ? 2'd1 : 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      crc         <= CRC_PRESET;
      ack_req     <= 1'b0;
      setup_irq   <= 1'b0;
      hw_req      <= 1'b0;
      status      <= ST_IDLE;
      data_toggle <= 1'b0;
      xfer_type   <= 2'd0;
      req_type    <= '0;
      req_code    <= '0;
      req_value   <= '0;
      req_index   <= '0;
      req_length  <= '0;
      for (int i = 0; i < REQ_BYTES; i++) sh[i] <= '0;
    end else begin
      ack_req   <= 1'b0;
      setup_irq <= 1'b0;
      if (setup_start) begin
        busy <= 1'b1;
        cnt  <= '0;
        crc  <= CRC_PRESET;
      end else if (take) begin
        if (cnt < CW'(REQ_BYTES)) sh[cnt[2:0]] <= rx_byte;
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        crc <= crc_nx;
        if (done) begin
          busy <= 1'b0;
          if (good) begin
            ack_req     <= 1'b1;
            setup_irq   <= !hw_in;
            hw_req      <= hw_in;
            status      <= ST_DATAIN;
            data_toggle <= 1'b1;
            xfer_type   <= xt_in;
            req_type    <= sh[0];
            req_code    <= sh[1];
            req_value   <= {sh[3], sh[2]};
            req_index   <= {sh[5], sh[4]};
            req_length  <= len_in;
          end else begin
            status <= ST_RXERR;
          end
        end
      end
    end
  end
endmodule

module usb_setup_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_last,
  input logic        ack_req,
  input logic        setup_irq,
  input logic        hw_req,
  input logic [1:0]  status,
  input logic        data_toggle,
  input logic [1:0]  xfer_type,
  input logic [7:0]  req_type,
  input logic [15:0] req_length
);
  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !ack_req);
  assert_ack_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(rx_valid && rx_last));
  assert_ack_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (status == 2'd1 && data_toggle));
  assert_err_no_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> !ack_req);
  assert_irq_sw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    setup_irq |-> (ack_req && !hw_req));
  assert_hw_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && hw_req) |-> !setup_irq);
  assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |-> ($stable(req_type) && $stable(req_length)));
  assert_xfer_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> ((req_length == 16'd0) == (xfer_type == 2'd3)));
endmodule

bind usb_setup_rx usb_setup_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
  .ack_req(ack_req), .setup_irq(setup_irq), .hw_req(hw_req), .status(status),
  .data_toggle(data_toggle), .xfer_type(xfer_type), .req_type(req_type),
  .req_length(req_length)
);

// File: tb/usb_setup_rx_bench.sv
module usb_setup_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_start = 1'b0, rx_valid = 1'b0, rx_last = 1'b0, rx_data0 = 1'b1;
  logic [7:0] rx_byte = '0;
  logic ack_req, setup_irq, hw_req, data_toggle;
  logic [1:0] status, xfer_type;
  logic [7:0] req_type, req_code;
  logic [15:0] req_value, req_index, req_length;

  int n_chk = 0, n_fail = 0;
  logic [7:0] pkt [12];

  always #2.5 clk = ~clk;

  usb_setup_rx u_usb_setup_rx (
    .clk(clk), .rst_n(rst_n), .setup_start(setup_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_last(rx_last), .rx_data0(rx_data0),
    .ack_req(ack_req), .setup_irq(setup_irq), .hw_req(hw_req), .status(status),
    .data_toggle(data_toggle), .xfer_type(xfer_type), .req_type(req_type),
    .req_code(req_code), .req_value(req_value), .req_index(req_index),
    .req_length(req_length)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic make_pkt(input logic [7:0] t, input logic [7:0] c,
                          input logic [15:0] v, input logic [15:0] i, input logic [15:0] l);
    logic [15:0] crc;
    pkt[0] = t; pkt[1] = c;
    pkt[2] = v[7:0]; pkt[3] = v[15:8];
    pkt[4] = i[7:0]; pkt[5] = i[15:8];
    pkt[6] = l[7:0]; pkt[7] = l[15:8];
    crc = 16'hFFFF;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 8; b++)
        crc = ((crc[0] ^ pkt[k][b]) != 1'b0) ? ((crc >> 1) ^ 16'hA001) : (crc >> 1);
    crc = ~crc;
    pkt[8] = crc[7:0]; pkt[9] = crc[15:8];
    pkt[10] = 8'h5A; pkt[11] = 8'hA5;
  endtask

  task automatic send(input int n, input bit d0, input bit open);
    if (open) begin
      @(negedge clk); setup_start = 1'b1;
      @(negedge clk); setup_start = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      if (k != 0) @(negedge clk);
      rx_valid = 1'b1; rx_byte = pkt[k]; rx_last = (k == n - 1); rx_data0 = d0;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_data0 = 1'b1;
  endtask

  task automatic expect_ok(input string req, input logic [7:0] t, input logic [7:0] c,
                           input logic [15:0] v, input logic [15:0] i, input logic [15:0] l,
                           input bit hw, input logic [1:0] xt);
    chk(ack_req == 1'b1, "R3", "ack pulse", ack_req, 1);
    chk(status == 2'd1 && data_toggle, "R7", "status/toggle", {status, data_toggle}, 3'b011);
    chk(req_type == t && req_code == c, "R2", "type/code", {req_type, req_code}, {t, c});
    chk(req_value == v && req_index == i && req_length == l, "R2", "value/index/length",
        {req_value, req_index}, {v, i});
    chk(hw_req == hw, hw ? "R8" : "R9", "hw flag", hw_req, hw);
    chk(setup_irq == !hw, hw ? "R8" : "R9", "irq", setup_irq, !hw);
    chk(xfer_type == xt, req, "xfer type", xfer_type, xt);
    @(negedge clk);
    chk(!ack_req && !setup_irq, "R3", "pulse width", {ack_req, setup_irq}, 0);
  endtask

  task automatic expect_err(input string req, input logic [15:0] keep_len, input logic [7:0] keep_type);
    chk(!ack_req && !setup_irq, req, "no ack/irq", {ack_req, setup_irq}, 0);
    chk(status == 2'd2, req, "status RX_ERR", status, 2);
    chk(req_length == keep_len && req_type == keep_type, "R4", "fields kept",
        {req_type, req_length}, {keep_type, keep_len});
    @(negedge clk);
    chk(!ack_req, req, "no late ack", ack_req, 0);
  endtask

  task automatic t_reset;
    chk(status == 2'd0 && !data_toggle && !ack_req && !setup_irq && !hw_req && xfer_type == 0,
        "R1", "control outputs", {status, data_toggle, ack_req, setup_irq, hw_req, xfer_type}, 0);
    chk(req_type == 0 && req_code == 0 && req_value == 0 && req_index == 0 && req_length == 0,
        "R1", "fields", {req_value, req_index}, 0);
  endtask

  task automatic t_read;
    make_pkt(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0040);
    send(10, 1'b1, 1'b1);
    expect_ok("R10", 8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0040, 1'b0, 2'd1);
  endtask

  task automatic t_hw_addr;
    make_pkt(8'h00, 8'h05, 16'h0007, 16'h0000, 16'h0000);
    send(10, 1'b1, 1'b1);
    expect_ok("R10", 8'h00, 8'h05, 16'h0007, 16'h0000, 16'h0000, 1'b1, 2'd3);
  endtask

  task automatic t_hw_getcfg;
    make_pkt(8'h80, 8'h08, 16'h0000, 16'h0000, 16'h0001);
    send(10, 1'b1, 1'b1);
    expect_ok("R8", 8'h80, 8'h08, 16'h0000, 16'h0000, 16'h0001, 1'b1, 2'd1);
  endtask

  task automatic t_vendor_write;
    make_pkt(8'h40, 8'h0B, 16'hBEEF, 16'h1234, 16'h0004);
    send(10, 1'b1, 1'b1);
    expect_ok("R10", 8'h40, 8'h0B, 16'hBEEF, 16'h1234, 16'h0004, 1'b0, 2'd2);
  endtask

  task automatic t_class_code9;
    make_pkt(8'h21, 8'h09, 16'h0200, 16'h0003, 16'h0000);
    send(10, 1'b1, 1'b1);
    expect_ok("R9", 8'h21, 8'h09, 16'h0200, 16'h0003, 16'h0000, 1'b0, 2'd3);
  endtask

  task automatic t_bad_crc;
    make_pkt(8'h80, 8'h06, 16'h0200, 16'h0000, 16'h00FF);
    pkt[9] = pkt[9] ^ 8'h10;
    send(10, 1'b1, 1'b1);
    expect_err("R4", 16'h0000, 8'h21);
  endtask

  task automatic t_bad_len;
    make_pkt(8'hC0, 8'h01, 16'h0000, 16'h0000, 16'h0010);
    send(9, 1'b1, 1'b1);
    expect_err("R5", 16'h0000, 8'h21);
    make_pkt(8'hC0, 8'h01, 16'h0000, 16'h0000, 16'h0010);
    send(11, 1'b1, 1'b1);
    expect_err("R5", 16'h0000, 8'h21);
  endtask

  task automatic t_data1;
    make_pkt(8'hC0, 8'h01, 16'h0000, 16'h0000, 16'h0010);
    send(10, 1'b0, 1'b1);
    expect_err("R6", 16'h0000, 8'h21);
  endtask

  task automatic t_idle_ignored;
    make_pkt(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0012);
    send(10, 1'b1, 1'b1);
    @(negedge clk);
    make_pkt(8'hC1, 8'h22, 16'h0000, 16'h0000, 16'h0033);
    send(10, 1'b1, 1'b0);
    chk(!ack_req && !setup_irq, "R11", "no ack when idle", ack_req, 0);
    chk(status == 2'd1, "R11", "status kept", status, 1);
    chk(req_type == 8'h80 && req_length == 16'h0012, "R11", "fields kept",
        {req_type, req_length}, {8'h80, 16'h0012});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_read;
    t_hw_addr;
    t_hw_getcfg;
    t_vendor_write;
    t_class_code9;
    t_bad_crc;
    t_bad_len;
    t_data1;
    t_idle_ignored;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule